// File: doc/BRIEF.md
# Indirect Entry Table Access Port

This block holds a table of 68-bit entries and lets software reach them through a small register window instead of mapping the whole table. Software first fills three 32-bit staging words. It then writes an index to a control register with the top bit set, and the staged value is stored into that entry. Writing an index with the top bit clear does the reverse: the entry is copied into the staging words, and software reads it back from there.

The staging words hold the entry in reversed order. The word at the highest offset carries entry bits 31:0, the middle word carries bits 63:32, and the lowest word carries only bits 67:64. A one-cycle clear input sets every entry to zero, and zero is the free entry type. A read-only identification register reports a revision number.

Top module: `tbl_access_port`

## Requirements
- R1: After reset, all three staging words read zero and every table entry is zero.
- R2: The identification register at offset 0x00 reads the major revision in bits 15:8 and the minor revision in bits 7:0, with every other bit zero.
- R3: Each staging word at 0x34, 0x38 or 0x3C reads back the last value written to it. Bits 31:4 of the word at 0x34 always read zero, and writes to those bits have no effect.
- R4: A write to the control register at 0x20 with bit 31 set stores {word 0x34[3:0], word 0x38, word 0x3C} into the entry chosen by index bits 9:0, so entry bits 67:64, 63:32 and 31:0 come from those three words in that order.
- R5: A write to the control register with bit 31 clear copies the chosen entry into the staging words in the same bit mapping. A read issued in the cycle after that write already returns the new value.
- R6: If index bits 9:0 are at or above the table depth (64 by default), the control write has no effect: the staging words keep their values and no entry changes, including the entry that the low index bits alone would select.
- R7: A one-cycle pulse on the clear input sets every entry to zero and leaves the staging words unchanged.
- R8: Reads of offsets that are not mapped return zero, and writes to them change no staging word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte offset |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| clearPulse | input | 1 | Clears all table entries |

## Verification
A wrong entry inside the table stays hidden until software loads that index. It then appears in the staging words in the cycle that follows the control write. For this reason the bench stores distinct patterns, overwrites the staging words and loads the entries back, so any corruption from a commit, a clear or an ignored index shows up at the very next read. A swapped word order or a widened top word shows up at once in the staging-word readback.

// File: rtl/tbl_access_pkg.sv
package tbl_access_pkg;
  localparam int ENTRY_W = 68;
  localparam logic [7:0] OFS_ID   = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h20;
  localparam logic [7:0] OFS_WD0  = 8'h34;
  localparam logic [7:0] OFS_WD1  = 8'h38;
  localparam logic [7:0] OFS_WD2  = 8'h3C;
  localparam int CMD_BIT = 31;

  typedef struct packed {
    logic [2:0] wordWe;
    logic       load;
    logic       commit;
    logic       clear;
  } tblStrobe_t;
endpackage

// File: rtl/tbl_access_ctrl.sv
module tbl_access_ctrl
  import tbl_access_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int IDXF_W  = 10,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic [7:0]       busAddr,
  input  logic [31:0]      busWrData,
  input  logic             clearPulse,
  output tblStrobe_t       stb,
  output logic [IDX_W-1:0] idx
);
  logic ctrlWr;
  logic idxOk;

  assign ctrlWr = busWrEn && (busAddr == OFS_CTRL);
  assign idxOk  = {22'd0, busWrData[IDXF_W-1:0]} < 32'(DEPTH);
  assign idx    = busWrData[IDX_W-1:0];

  always_comb begin
    stb           = '0;
    stb.wordWe[0] = busWrEn && (busAddr == OFS_WD0);
    stb.wordWe[1] = busWrEn && (busAddr == OFS_WD1);
    stb.wordWe[2] = busWrEn && (busAddr == OFS_WD2);
    stb.commit    = ctrlWr && idxOk && busWrData[CMD_BIT];
    stb.load      = ctrlWr && idxOk && !busWrData[CMD_BIT];
    stb.clear     = clearPulse;
  end

  // R6: load and commit never come together, and neither comes from a bad index
  a_r6_one_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.load, stb.commit}));
  a_r6_range: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load || stb.commit) |-> (busWrData[IDXF_W-1:0] < IDXF_W'(DEPTH)));
endmodule

// File: rtl/tbl_access_dp.sv
module tbl_access_dp
  import tbl_access_pkg::*;
#(
  parameter int DEPTH          = 64,
  parameter logic [7:0] REV_MJ = 8'h02,
  parameter logic [7:0] REV_MN = 8'h15,
  localparam int IDX_W         = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tblStrobe_t       stb,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       busAddr,
  input  logic [31:0]      busWrData,
  output logic [31:0]      busRdData
);
  logic [ENTRY_W-1:0] tbl [DEPTH];
  logic [3:0]  wd0;
  logic [31:0] wd1;
  logic [31:0] wd2;
  logic [ENTRY_W-1:0] staged;

  assign staged = {wd0, wd1, wd2};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (stb.clear) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (stb.commit) begin
      tbl[idx] <= staged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wd0 <= '0;
      wd1 <= '0;
      wd2 <= '0;
    end else if (stb.load) begin
      {wd0, wd1, wd2} <= tbl[idx];
    end else begin
      if (stb.wordWe[0]) wd0 <= busWrData[3:0];
      if (stb.wordWe[1]) wd1 <= busWrData;
      if (stb.wordWe[2]) wd2 <= busWrData;
    end
  end

  always_comb begin
    case (busAddr)
      OFS_ID:  busRdData = {16'd0, REV_MJ, REV_MN};
      OFS_WD0: busRdData = {28'd0, wd0};
      OFS_WD1: busRdData = wd1;
      OFS_WD2: busRdData = wd2;
      default: busRdData = '0;
    endcase
  end

  a_r4_commit: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && !stb.clear) |=> (tbl[$past(idx)] == $past(staged)));
  a_r5_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (staged == $past(tbl[idx])));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wordWe == 3'b000 && !stb.load) |=> $stable(staged));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (tbl[0] == '0 && tbl[DEPTH-1] == '0));
  a_r3_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFS_WD0) |-> (busRdData[31:4] == 28'd0));
endmodule

// File: rtl/tbl_access_port.sv
module tbl_access_port
  import tbl_access_pkg::*;
#(
  parameter int DEPTH          = 64,
  parameter int IDXF_W         = 10,
  parameter logic [7:0] REV_MJ = 8'h02,
  parameter logic [7:0] REV_MN = 8'h15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic        clearPulse
);
  localparam int IDX_W = $clog2(DEPTH);
  tblStrobe_t       stb;
  logic [IDX_W-1:0] idx;

  tbl_access_ctrl #(.DEPTH(DEPTH), .IDXF_W(IDXF_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .clearPulse(clearPulse), .stb(stb), .idx(idx));

  tbl_access_dp #(.DEPTH(DEPTH), .REV_MJ(REV_MJ), .REV_MN(REV_MN)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(idx), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData));
endmodule

// File: tb/test_tbl_access_port.sv
module test_tbl_access_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic clearPulse = 1'b0;
  int nChk = 0;
  int nFail = 0;
  logic [67:0] model [64];

  always #4 clk = ~clk;

  tbl_access_port i_tbl_access_port (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .clearPulse(clearPulse));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic stage(logic [67:0] e);
    wr(8'h34, {28'hFFFFFFF, e[67:64]});
    wr(8'h38, e[63:32]);
    wr(8'h3C, e[31:0]);
  endtask

  task automatic chkWords(string req, logic [67:0] e);
    logic [31:0] d;
    rd(8'h34, d); chk(req, d, {28'd0, e[67:64]});
    rd(8'h38, d); chk(req, d, e[63:32]);
    rd(8'h3C, d); chk(req, d, e[31:0]);
  endtask

  task automatic loadChk(string req, int i);
    wr(8'h20, 32'(i));
    chkWords(req, model[i]);
  endtask

  task automatic tReset();
    logic [31:0] d;
    chkWords("R1", 68'd0);
    rd(8'h00, d); chk("R2", d, 32'h0000_0215);
    loadChk("R1", 63);
  endtask

  task automatic tWords();
    logic [31:0] d;
    wr(8'h34, 32'hABCD_1239);
    rd(8'h34, d); chk("R3", d, 32'h0000_0009);
    wr(8'h38, 32'h1234_5678);
    rd(8'h38, d); chk("R3", d, 32'h1234_5678);
    wr(8'h3C, 32'hDEAD_BEEF);
    rd(8'h3C, d); chk("R3", d, 32'hDEAD_BEEF);
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, d); chk("R8", d, 32'd0);
    chkWords("R8", {4'h9, 32'h1234_5678, 32'hDEAD_BEEF});
  endtask

  task automatic tCommitLoad();
    logic [67:0] pats [4];
    int ids [4];
    pats[0] = {4'hA, 32'h0102_0304, 32'h0506_0708}; ids[0] = 0;
    pats[1] = {4'h5, 32'hFFFF_0000, 32'h0000_FFFF}; ids[1] = 63;
    pats[2] = {4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF}; ids[2] = 5;
    pats[3] = {4'h1, 32'h8000_0001, 32'h7FFF_FFFE}; ids[3] = 31;
    for (int k = 0; k < 4; k++) begin
      stage(pats[k]);
      wr(8'h20, 32'h8000_0000 | 32'(ids[k]));
      model[ids[k]] = pats[k];
    end
    stage({4'h3, 32'h3333_3333, 32'h3333_3333});
    for (int k = 0; k < 4; k++) loadChk(k[0] ? "R5" : "R4", ids[k]);
  endtask

  task automatic tRange();
    stage({4'h6, 32'h6666_6666, 32'h6666_6666});
    wr(8'h20, 32'h8000_0040);
    wr(8'h20, 32'h8000_03C0);
    wr(8'h20, 32'h0000_0040);
    chkWords("R6", {4'h6, 32'h6666_6666, 32'h6666_6666});
    loadChk("R6", 0);
  endtask

  task automatic tClear();
    stage({4'h7, 32'h7777_0000, 32'h0000_7777});
    @(negedge clk);
    clearPulse = 1'b1;
    @(negedge clk);
    clearPulse = 1'b0;
    for (int i = 0; i < 64; i++) model[i] = '0;
    chkWords("R7", {4'h7, 32'h7777_0000, 32'h0000_7777});
    loadChk("R7", 0);
    loadChk("R7", 5);
    loadChk("R7", 63);
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChk - nFail + 1, nChk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tWords();
    tCommitLoad();
    tRange();
    tClear();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule